// File: doc/BRIEF.md
# Vertical Lock Flywheel Detector

This block keeps a display timing chain's internally generated vertical pulse in step with an external vertical reference. Each field it compares the rising edge of the internal pulse, produced by the line counter from horizontal timing, with the rising edge of a chosen external reference. One candidate reference is the vertical pulse separated from composite sync. The other is a direct vertical input pin. A select bit picks which one is used. Both external inputs are asynchronous, so they are resynchronised and edge-detected before use.

The detector has hysteresis. While it is searching, every rising edge of the selected reference sends a one-cycle reset request to the line counter, so the timing follows the reference pulse for pulse. Lock is declared only after a run of consecutive fields in which the two edges coincide. Once locked, reset requests stop and the internal chain flywheels. Lock is released only after a run of consecutive fields that fail to coincide. A field in which no reference edge arrives at all still counts as a failed field, by timeout.

Top module: `vlock_flywheel`

## Requirements
- R1: On reset, and in the cycle after any clock with `rst` high, `lock` is 0 and `cnt_reset` is 0. The acquisition and release counts are cleared.
- R2: While `lock` is 0, each rising edge of the selected external input makes `cnt_reset` go high for exactly one cycle. The pin is sampled by two synchronizer flops and the request is registered, so `cnt_reset` is high in the cycle that follows the third rising clock edge after the pin goes high.
- R3: `lock` goes to 1 after ACQ_FIELDS (default 4) consecutive coincident fields, and not after fewer.
- R4: While searching, a failed field returns the acquisition count to zero, so ACQ_FIELDS new coincident fields are needed.
- R5: Two edges coincide when they occur within WIN_LINES (default 1) line ticks of each other, in either order. At 2 lines apart, the field fails.
- R6: While `lock` is 1, edges on the selected external input produce no `cnt_reset`.
- R7: `lock` returns to 0 after REL_FIELDS (default 3) consecutive failed fields. A coincident field while locked clears the failure count.
- R8: If neither a reference edge nor a field decision occurs for FIELD_LINES + MISS_SLACK line ticks, that period counts as a failed field.
- R9: With `src_sel` = 0 the composite-sync input `ext_csync_v` is the reference, and with `src_sel` = 1 the direct input `ext_vin` is. The unselected input produces no reset request and takes no part in coincidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse at the start of each line |
| int_vpulse | input | 1 | Internal vertical pulse from the line counter (synchronous) |
| ext_csync_v | input | 1 | Vertical pulse separated from composite sync (asynchronous) |
| ext_vin | input | 1 | Direct vertical reference pin (asynchronous) |
| src_sel | input | 1 | Reference select: 0 composite-sync pulse, 1 direct pin |
| lock | output | 1 | High while the timing is locked and flywheeling |
| cnt_reset | output | 1 | One-cycle request to reset the line counter |

## Verification
Some rules are checked by properties on every cycle. A reset request is a single cycle, always follows an edge on the selected reference, and never comes while locked. Lock rises only on a coincident field and falls only on a failed one. The exact run lengths of acquisition and release cannot be seen by a single-cycle property, and neither can the ±1-line window edges, the timeout, or the masking of the unselected input. Those are shown by the bench's field sequences, which count lock state and reset requests field by field.

// File: rtl/vlock_pkg.sv
package vlock_pkg;

    // Result of one field comparison.
    typedef struct packed {
        logic valid;
        logic hit;
    } vlk_outcome_t;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_HOLD = 1'b1
    } vlk_state_t;

    // Width of a counter that must hold values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vlock_edge_sync.sv
module vlock_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic lvl;
    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = din;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign lvl = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/vlock_phase_cmp.sv
module vlock_phase_cmp
    import vlock_pkg::*;
#(
    parameter int WIN_LINES = 1,
    parameter int WD_LIMIT  = 266
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_tick,
    input  logic         int_e,
    input  logic         ext_e,
    output vlk_outcome_t outcome
);
    localparam int AGE_W = cnt_w(WIN_LINES + 1);
    localparam int WD_W  = cnt_w(WD_LIMIT);
    localparam logic [AGE_W-1:0] AGE_END = AGE_W'(WIN_LINES);
    localparam logic [WD_W-1:0]  WD_END  = WD_W'(WD_LIMIT - 1);

    logic             int_pend, ext_pend;
    logic [AGE_W-1:0] int_age, ext_age;
    logic [WD_W-1:0]  wd_cnt;
    logic             hit, win_miss, wd_miss;

    always_comb begin
        hit      = (int_e & ext_e) | (ext_e & int_pend) | (int_e & ext_pend);
        win_miss = !hit && int_pend && line_tick && (int_age == AGE_END);
        wd_miss  = !hit && !win_miss && !ext_e && line_tick && (wd_cnt == WD_END);
        outcome.valid = hit | win_miss | wd_miss;
        outcome.hit   = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_pend <= 1'b0;
            ext_pend <= 1'b0;
            int_age  <= '0;
            ext_age  <= '0;
        end else if (hit) begin
            int_pend <= 1'b0;
            ext_pend <= 1'b0;
        end else begin
            if (int_e) begin
                int_pend <= 1'b1;
                int_age  <= '0;
            end else if (int_pend && line_tick) begin
                if (int_age == AGE_END) int_pend <= 1'b0;
                else                    int_age  <= int_age + 1'b1;
            end
            if (ext_e) begin
                ext_pend <= 1'b1;
                ext_age  <= '0;
            end else if (ext_pend && line_tick) begin
                if (ext_age == AGE_END) ext_pend <= 1'b0;
                else                    ext_age  <= ext_age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        wd_cnt <= '0;
        else if (ext_e || outcome.valid) wd_cnt <= '0;
        else if (line_tick)             wd_cnt <= wd_cnt + 1'b1;
    end
endmodule

// File: rtl/vlock_lock_fsm.sv
module vlock_lock_fsm
    import vlock_pkg::*;
#(
    parameter int ACQ_FIELDS = 4,
    parameter int REL_FIELDS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  vlk_outcome_t outcome,
    input  logic         ext_e,
    output logic         lock,
    output logic         cnt_reset
);
    localparam int MAXRUN = (ACQ_FIELDS > REL_FIELDS) ? ACQ_FIELDS : REL_FIELDS;
    localparam int RUN_W  = cnt_w(MAXRUN);
    localparam logic [RUN_W-1:0] ACQ_END = RUN_W'(ACQ_FIELDS - 1);
    localparam logic [RUN_W-1:0] REL_END = RUN_W'(REL_FIELDS - 1);

    vlk_state_t       state;
    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SEEK;
            run_cnt   <= '0;
            cnt_reset <= 1'b0;
        end else begin
            cnt_reset <= ext_e && (state == ST_SEEK);
            if (outcome.valid) begin
                unique case (state)
                    ST_SEEK: begin
                        if (!outcome.hit) begin
                            run_cnt <= '0;
                        end else if (run_cnt == ACQ_END) begin
                            state   <= ST_HOLD;
                            run_cnt <= '0;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (outcome.hit) begin
                            run_cnt <= '0;
                        end else if (run_cnt == REL_END) begin
                            state   <= ST_SEEK;
                            run_cnt <= '0;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_SEEK;
                endcase
            end
        end
    end

    assign lock = (state == ST_HOLD);
endmodule

// File: rtl/vlock_flywheel.sv
module vlock_flywheel
    import vlock_pkg::*;
#(
    parameter int ACQ_FIELDS  = 4,
    parameter int REL_FIELDS  = 3,
    parameter int WIN_LINES   = 1,
    parameter int FIELD_LINES = 262,
    parameter int MISS_SLACK  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_tick,
    input  logic int_vpulse,
    input  logic ext_csync_v,
    input  logic ext_vin,
    input  logic src_sel,
    output logic lock,
    output logic cnt_reset
);
    localparam int NUM_REF  = 2;
    localparam int WD_LIMIT = FIELD_LINES + MISS_SLACK;

    logic [NUM_REF-1:0] ext_raw;
    logic [NUM_REF-1:0] ext_edge;
    logic               int_edge;
    logic               sel_edge;
    vlk_outcome_t       fld_outcome;

    assign ext_raw = {ext_vin, ext_csync_v};

    generate
        for (genvar gi = 0; gi < NUM_REF; gi++) begin : g_ref
            vlock_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (ext_raw[gi]),
                .rise (ext_edge[gi])
            );
        end
    endgenerate

    vlock_edge_sync #(.STAGES(0)) u_int_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (int_vpulse),
        .rise (int_edge)
    );

    assign sel_edge = src_sel ? ext_edge[1] : ext_edge[0];

    vlock_phase_cmp #(
        .WIN_LINES (WIN_LINES),
        .WD_LIMIT  (WD_LIMIT)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .int_e     (int_edge),
        .ext_e     (sel_edge),
        .outcome   (fld_outcome)
    );

    vlock_lock_fsm #(
        .ACQ_FIELDS (ACQ_FIELDS),
        .REL_FIELDS (REL_FIELDS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .outcome   (fld_outcome),
        .ext_e     (sel_edge),
        .lock      (lock),
        .cnt_reset (cnt_reset)
    );
endmodule

// File: rtl/vlock_flywheel_chk.sv
module vlock_flywheel_chk
    import vlock_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         lock,
    input logic         cnt_reset,
    input vlk_outcome_t outcome,
    input logic         sel_edge
);
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cnt_reset |=> !cnt_reset); // R2

    AST_RESET_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        cnt_reset |-> $past(sel_edge)); // R2

    AST_NO_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock |=> !cnt_reset); // R6

    AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(outcome.valid && outcome.hit)); // R3

    AST_RELEASE_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        $fell(lock) |-> $past(outcome.valid && !outcome.hit)); // R7
endmodule

bind vlock_flywheel vlock_flywheel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lock      (lock),
    .cnt_reset (cnt_reset),
    .outcome   (fld_outcome),
    .sel_edge  (sel_edge)
);

// File: tb/vlock_flywheel_bench.sv
module vlock_flywheel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_CYC   = 4;
    localparam int FLINES     = 30;
    localparam int SLACK      = 4;
    localparam int LIMIT      = FLINES + SLACK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_tick = 1'b0, int_vpulse = 1'b0;
    logic ext_csync_v = 1'b0, ext_vin = 1'b0, src_sel = 1'b0;
    logic lock, cnt_reset;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlock_flywheel #(
        .FIELD_LINES (FLINES),
        .MISS_SLACK  (SLACK)
    ) u_vlock_flywheel (
        .clk         (clk),
        .rst         (rst),
        .line_tick   (line_tick),
        .int_vpulse  (int_vpulse),
        .ext_csync_v (ext_csync_v),
        .ext_vin     (ext_vin),
        .src_sel     (src_sel),
        .lock        (lock),
        .cnt_reset   (cnt_reset)
    );

    typedef struct packed {
        logic sel;
        int   int_at;
        int   sel_at;
        int   oth_at;
        int   exp_lock;
        int   exp_res;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5, 5, -1, 0, 1},  // R5 hit same line
        '{1'b0, 5, 5, -1, 0, 1},
        '{1'b0, 5, 6, -1, 0, 1},  // R5 one line late
        '{1'b0, 5, 7, -1, 0, 1},  // R4 R5 two lines late -> miss
        '{1'b0, 5, 4, -1, 0, 1},  // R5 one line early
        '{1'b0, 5, 5, -1, 0, 1},
        '{1'b0, 5, 5, -1, 0, 1},
        '{1'b0, 5, 5, -1, 1, 1},  // R3 fourth hit locks
        '{1'b0, 5, -1, -1, 1, 0}, // R7 miss 1, no reference
        '{1'b0, 5, 3, -1, 1, 0},  // R6 R7 miss 2, two lines early
        '{1'b0, 5, 5, -1, 1, 0},  // R7 hit clears misses
        '{1'b0, 5, 8, -1, 1, 0},
        '{1'b0, 5, 8, -1, 1, 0},
        '{1'b0, 5, -1, -1, 0, 0}, // R7 third miss releases
        '{1'b1, 5, 5, 15, 0, 1},  // R9 direct pin selected
        '{1'b1, 5, 5, 15, 0, 1},
        '{1'b1, 5, 6, 15, 0, 1},
        '{1'b1, 5, 5, 15, 1, 1}   // R9 R3 lock on direct pin
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_lines(input int nlines, input logic sel, input int int_at,
                             input int sel_at, input int oth_at, output int nres);
        nres = 0;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int c = 0; c < LINE_CYC; c++) begin
                @(negedge clk);
                if (cnt_reset) nres++;
                src_sel    = sel;
                line_tick  = (c == 0);
                int_vpulse = (ln == int_at) && (c == 1);
                if (sel) begin
                    ext_vin     = (ln == sel_at);
                    ext_csync_v = (ln == oth_at);
                end else begin
                    ext_csync_v = (ln == sel_at);
                    ext_vin     = (ln == oth_at);
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        line_tick = 1'b0; int_vpulse = 1'b0;
        ext_csync_v = 1'b0; ext_vin = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 lock after reset", int'(lock), 0);
        check("R1 cnt_reset after reset", int'(cnt_reset), 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        int nres;
        do_reset();

        // R2: exact latency of the reset request while searching.
        src_sel = 1'b0;
        @(negedge clk);
        ext_csync_v = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 no request after 2 edges", int'(cnt_reset), 0);
        @(negedge clk);
        check("R2 request after 3 edges", int'(cnt_reset), 1);
        @(negedge clk);
        check("R2 request lasts one cycle", int'(cnt_reset), 0);
        ext_csync_v = 1'b0;

        // R9: unselected pin raises no request.
        repeat (2) @(negedge clk);
        ext_vin = 1'b1;
        nres = 0;
        repeat (6) begin
            @(negedge clk);
            if (cnt_reset) nres++;
        end
        ext_vin = 1'b0;
        check("R9 unselected pin ignored", nres, 0);

        // Table of fields.
        for (int i = 0; i < NV; i++) begin
            run_lines(FLINES, VEC[i].sel, VEC[i].int_at, VEC[i].sel_at,
                      VEC[i].oth_at, nres);
            check($sformatf("R3/R7 lock field %0d", i), int'(lock), VEC[i].exp_lock);
            check($sformatf("R2/R6/R9 requests field %0d", i), nres, VEC[i].exp_res);
        end

        // R8: silence after lock, released by timeouts.
        run_lines(74, 1'b1, -1, -1, -1, nres);
        check("R8 still locked before third timeout", int'(lock), 1);
        run_lines(6, 1'b1, -1, -1, -1, nres);
        check("R8 released by timeouts", int'(lock), 0);

        // R1: reset while locked.
        for (int f = 0; f < 4; f++) run_lines(FLINES, 1'b1, 5, 5, -1, nres);
        check("R3 relocked on direct pin", int'(lock), 1);
        do_reset();
        run_lines(2, 1'b1, -1, -1, -1, nres);
        check("R1 stays unlocked after reset", int'(lock), 0);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule